// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs one 8-bit parallel port with a strobe/acknowledge handshake on behalf of one port group. A mode-entry command selects the direction. As a latched input channel, it captures the peripheral's data while the peripheral strobe is low. It raises a buffer-full flag and, if enabled, an interrupt to the CPU. As a latched output channel, it holds the last CPU-written byte on the pins and signals output-buffer-full (active low) to the peripheral. It raises an interrupt when the peripheral acknowledges.

The single peripheral handshake input acts as the strobe in input direction and as the acknowledge in output direction. It passes through a two-flop synchroniser before use. The CPU read and write strobes arrive already decoded for this port and are synchronous to the clock. The interrupt enable is written by a bit set/reset command addressed to a port C bit position. A parameter picks the group: the upper group (with the 8-bit port plus the upper status bits) or the lower group. The live handshake status appears on an 8-bit port C image, together with a mask of the bits the block owns.

Top module: `hs_port`

## Requirements
- R1: After reset, ibf_o=0, intr_o=0, obf_no=1, pins_oe_o=0 (input direction) and the interrupt enable is clear.
- R2: A cycle with cfg_load_i=1 sets the direction (cfg_in_i=1 input, 0 output). It clears ibf_o, intr_o and the interrupt enable, and drives obf_no high.
- R3: In input direction, while the synchronised hs_ni is low, pins_i is loaded into the input latch and ibf_o goes to 1. rdata_o always returns the input latch.
- R4: In input direction, ibf_o clears on the rising edge of rd_ni (end of the read). It is not cleared on the falling edge.
- R5: In input direction, intr_o sets when the synchronised strobe returns high while ibf_o=1 and the enable is set. It clears on the falling edge of rd_ni.
- R6: In output direction, the rising edge of wr_ni loads wdata_i into the output latch driven on pins_o and drives obf_no low. A low synchronised hs_ni (acknowledge) drives obf_no high.
- R7: In output direction, intr_o sets when the acknowledge returns high while obf_no=1 and the enable is set. It clears on the falling edge of wr_ni.
- R8: A bit set/reset command (bsr_valid_i, bit index bsr_bit_i, value bsr_set_i) writes the interrupt enable only at its mapped bit. The upper group uses bit 4 in input and bit 6 in output. The lower group uses bit 2. Commands to any other bit leave it unchanged.
- R9: pc_o carries the live status and is zero outside pc_mask_o. Upper group, input: intr at bit 3, synchronised strobe at bit 4, ibf at bit 5 (mask 0x38). Upper group, output: intr at bit 3, acknowledge at bit 6, obf_no at bit 7 (mask 0xC8). Lower group: intr at bit 0, ibf or obf_no at bit 1, strobe/acknowledge at bit 2 (mask 0x07).
- R10: pins_oe_o=1 only in output direction. In input direction, CPU writes leave pins_o and obf_no unchanged. In output direction, the handshake input leaves ibf_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Mode-entry command |
| cfg_in_i | input | 1 | Direction for mode entry, 1 = input |
| rd_ni | input | 1 | Decoded CPU read of the data port, active low |
| wr_ni | input | 1 | Decoded CPU write of the data port, active low |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Input latch contents |
| bsr_valid_i | input | 1 | Bit set/reset command valid |
| bsr_bit_i | input | 3 | Port C bit index of the command |
| bsr_set_i | input | 1 | Value written by the command |
| pins_i | input | 8 | Peripheral data in |
| pins_o | output | 8 | Output latch to peripheral |
| pins_oe_o | output | 1 | Output enable for the data pins |
| hs_ni | input | 1 | Strobe (input) or acknowledge (output), asynchronous, active low |
| intr_o | output | 1 | Interrupt request |
| ibf_o | output | 1 | Input buffer full |
| obf_no | output | 1 | Output buffer full, active low |
| pc_o | output | 8 | Port C status image |
| pc_mask_o | output | 8 | Port C bits owned by this group |

## Verification
The hardest situation to reach is the window inside a CPU read. At that point the interrupt has already been cleared by the falling edge, but the buffer-full flag must still read 1 until the rising edge. The write case is similar: the output interrupt drops at the start of a write while buffer-full only asserts at its end. The stimulus holds the read and write strobes low for several cycles and samples in the middle. It runs both group variants side by side on the same random sequence of mode entries, strobes, reads, writes and set/reset commands, so that each enable bit position is hit and missed.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned PC_W = 8;

  // interrupt-enable bit position in port C for a group/direction
  function automatic logic [2:0] inte_pos(input bit upper, input bit dir_in);
    if (!upper) return 3'd2;
    return dir_in ? 3'd4 : 3'd6;
  endfunction

  typedef struct packed {
    logic intr;
    logic full;  // ibf (input) or obf_n (output) pin level
    logic hs;    // synchronised strobe/ack level
  } hs_stat_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         hs_s_i,
  input  logic         hs_rise_i,
  input  logic         rd_fall_i,
  input  logic         rd_rise_i,
  input  logic         inte_i,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] latch_o,
  output logic         ibf_o,
  output logic         intr_o
);
  logic [W-1:0] latch_q;
  logic         ibf_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      ibf_q   <= 1'b0;
      intr_q  <= 1'b0;
    end else if (clr_i) begin
      ibf_q  <= 1'b0;
      intr_q <= 1'b0;
    end else if (en_i) begin
      if (!hs_s_i) begin
        latch_q <= pins_i;
        ibf_q   <= 1'b1;
      end else if (rd_rise_i) begin
        ibf_q <= 1'b0;
      end
      if (rd_fall_i) intr_q <= 1'b0;
      else if (hs_rise_i && ibf_q && inte_i) intr_q <= 1'b1;
    end
  end

  assign latch_o = latch_q;
  assign ibf_o   = ibf_q;
  assign intr_o  = intr_q;
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         hs_s_i,
  input  logic         hs_rise_i,
  input  logic         wr_fall_i,
  input  logic         wr_rise_i,
  input  logic         inte_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] latch_o,
  output logic         obf_no,
  output logic         intr_o
);
  logic [W-1:0] latch_q;
  logic         obf_nq, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      obf_nq  <= 1'b1;
      intr_q  <= 1'b0;
    end else if (clr_i) begin
      obf_nq <= 1'b1;
      intr_q <= 1'b0;
    end else if (en_i) begin
      if (wr_rise_i) begin
        latch_q <= wdata_i;
        obf_nq  <= 1'b0;
      end else if (!hs_s_i) begin
        obf_nq <= 1'b1;
      end
      if (wr_fall_i) intr_q <= 1'b0;
      else if (hs_rise_i && obf_nq && inte_i) intr_q <= 1'b1;
    end
  end

  assign latch_o = latch_q;
  assign obf_no  = obf_nq;
  assign intr_o  = intr_q;
endmodule

// File: rtl/hs_pc_map.sv
module hs_pc_map
  import hs_pkg::*;
#(
  parameter bit UPPER = 1'b1
) (
  input  logic            dir_in_i,
  input  hs_stat_t        stat_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] mask_o
);
  if (UPPER) begin : g_upper
    always_comb begin
      pc_o    = '0;
      pc_o[3] = stat_i.intr;
      if (dir_in_i) begin
        pc_o[4] = stat_i.hs;
        pc_o[5] = stat_i.full;
        mask_o  = 8'h38;
      end else begin
        pc_o[6] = stat_i.hs;
        pc_o[7] = stat_i.full;
        mask_o  = 8'hC8;
      end
    end
  end else begin : g_lower
    always_comb begin
      pc_o      = '0;
      pc_o[2:0] = {stat_i.hs, stat_i.full, stat_i.intr};
      mask_o    = 8'h07;
    end
  end
endmodule

// File: rtl/hs_port.sv
module hs_port
  import hs_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter bit          UPPER     = 1'b1,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_load_i,
  input  logic            cfg_in_i,
  input  logic            rd_ni,
  input  logic            wr_ni,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rdata_o,
  input  logic            bsr_valid_i,
  input  logic [2:0]      bsr_bit_i,
  input  logic            bsr_set_i,
  input  logic [W-1:0]    pins_i,
  output logic [W-1:0]    pins_o,
  output logic            pins_oe_o,
  input  logic            hs_ni,
  output logic            intr_o,
  output logic            ibf_o,
  output logic            obf_no,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] pc_mask_o
);
  logic dir_q, inte_q;
  logic hs_s, hs_q, rd_q, wr_q;
  logic hs_rise, rd_fall, rd_rise, wr_fall, wr_rise;
  logic in_ibf, in_intr, out_obf_n, out_intr;
  hs_stat_t stat;

  hs_sync #(.W(1), .STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hs_ni), .q_o(hs_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      hs_q <= hs_s;
      rd_q <= rd_ni;
      wr_q <= wr_ni;
    end
  end

  assign hs_rise = hs_s & ~hs_q;
  assign rd_fall = ~rd_ni & rd_q;
  assign rd_rise = rd_ni & ~rd_q;
  assign wr_fall = ~wr_ni & wr_q;
  assign wr_rise = wr_ni & ~wr_q;

  // direction and interrupt enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b1;
      inte_q <= 1'b0;
    end else if (cfg_load_i) begin
      dir_q  <= cfg_in_i;
      inte_q <= 1'b0;
    end else if (bsr_valid_i && bsr_bit_i == inte_pos(UPPER, dir_q)) begin
      inte_q <= bsr_set_i;
    end
  end

  hs_in_chan #(.W(W)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(dir_q), .clr_i(cfg_load_i),
    .hs_s_i(hs_s), .hs_rise_i(hs_rise), .rd_fall_i(rd_fall), .rd_rise_i(rd_rise),
    .inte_i(inte_q), .pins_i(pins_i), .latch_o(rdata_o),
    .ibf_o(in_ibf), .intr_o(in_intr)
  );

  hs_out_chan #(.W(W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(~dir_q), .clr_i(cfg_load_i),
    .hs_s_i(hs_s), .hs_rise_i(hs_rise), .wr_fall_i(wr_fall), .wr_rise_i(wr_rise),
    .inte_i(inte_q), .wdata_i(wdata_i), .latch_o(pins_o),
    .obf_no(out_obf_n), .intr_o(out_intr)
  );

  assign pins_oe_o = ~dir_q;
  assign intr_o    = dir_q ? in_intr : out_intr;
  assign ibf_o     = dir_q & in_ibf;
  assign obf_no    = dir_q | out_obf_n;

  assign stat.intr = intr_o;
  assign stat.full = dir_q ? ibf_o : obf_no;
  assign stat.hs   = hs_s;

  hs_pc_map #(.UPPER(UPPER)) u_map (
    .dir_in_i(dir_q), .stat_i(stat), .pc_o(pc_o), .mask_o(pc_mask_o)
  );
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_load_i,
  input logic       rd_ni,
  input logic       wr_ni,
  input logic       hs_s,
  input logic       dir_in,
  input logic       inte,
  input logic       intr_o,
  input logic       ibf_o,
  input logic       obf_no,
  input logic       pins_oe_o,
  input logic [7:0] pc_o,
  input logic [7:0] pc_mask_o
);
  AST_MODE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (!ibf_o && !intr_o && obf_no && !inte)); // R2

  AST_IBF_RD_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_ni) && dir_in && hs_s && !cfg_load_i) |=> !ibf_o); // R4

  AST_INTR_RD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_ni) && dir_in) |=> !intr_o); // R5

  AST_OBF_WR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_ni) && !dir_in && !cfg_load_i) |=> !obf_no); // R6

  AST_INTR_WR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wr_ni) && !dir_in) |=> !intr_o); // R7

  AST_PC_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o & ~pc_mask_o) == 8'h00); // R9

  AST_IN_DIR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_in |-> (obf_no && !pins_oe_o)); // R10
endmodule

bind hs_port hs_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .rd_ni(rd_ni),
  .wr_ni(wr_ni), .hs_s(hs_s), .dir_in(dir_q), .inte(inte_q), .intr_o(intr_o),
  .ibf_o(ibf_o), .obf_no(obf_no), .pins_oe_o(pins_oe_o), .pc_o(pc_o),
  .pc_mask_o(pc_mask_o)
);

// File: tb/sim_hs_port.sv
module sim_hs_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cfg_load = 0, cfg_in = 0, rd_n = 1, wr_n = 1, hs_n = 1;
  logic       bsr_valid = 0, bsr_set = 0;
  logic [2:0] bsr_bit = 0;
  logic [7:0] wdata = 0, pins_in = 0;
  logic [7:0] rdata_w [2], pins_w [2], pc_w [2], mask_w [2];
  logic       oe_w [2], intr_w [2], ibf_w [2], obfn_w [2];

  hs_port #(.UPPER(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_in_i(cfg_in),
    .rd_ni(rd_n), .wr_ni(wr_n), .wdata_i(wdata), .rdata_o(rdata_w[0]),
    .bsr_valid_i(bsr_valid), .bsr_bit_i(bsr_bit), .bsr_set_i(bsr_set),
    .pins_i(pins_in), .pins_o(pins_w[0]), .pins_oe_o(oe_w[0]), .hs_ni(hs_n),
    .intr_o(intr_w[0]), .ibf_o(ibf_w[0]), .obf_no(obfn_w[0]),
    .pc_o(pc_w[0]), .pc_mask_o(mask_w[0])
  );
  hs_port #(.UPPER(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_in_i(cfg_in),
    .rd_ni(rd_n), .wr_ni(wr_n), .wdata_i(wdata), .rdata_o(rdata_w[1]),
    .bsr_valid_i(bsr_valid), .bsr_bit_i(bsr_bit), .bsr_set_i(bsr_set),
    .pins_i(pins_in), .pins_o(pins_w[1]), .pins_oe_o(oe_w[1]), .hs_ni(hs_n),
    .intr_o(intr_w[1]), .ibf_o(ibf_w[1]), .obf_no(obfn_w[1]),
    .pc_o(pc_w[1]), .pc_mask_o(mask_w[1])
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model (index 0 = upper group, 1 = lower group)
  bit       e_dir = 1, e_ibf = 0, e_obfn = 1;
  bit       e_inte [2] = '{0, 0};
  bit       e_intr [2] = '{0, 0};
  bit [7:0] e_in = 0, e_out = 0;

  function automatic bit [2:0] e_pos(int g, bit dir);
    if (g == 1) return 3'd2;
    return dir ? 3'd4 : 3'd6;
  endfunction

  function automatic bit [7:0] e_pc(int g, bit dir, bit intr, bit ibf, bit obfn);
    if (g == 1) return {5'b0, 1'b1, (dir ? ibf : obfn), intr};
    if (dir) return {2'b00, ibf, 1'b1, intr, 3'b000};
    return {obfn, 1'b1, 2'b00, intr, 3'b000};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all();
    for (int g = 0; g < 2; g++) begin
      chk(e_dir ? "R5 intr" : "R7 intr", intr_w[g], e_intr[g]);
      chk("R3/R4 ibf", ibf_w[g], e_ibf);
      chk("R6 obf_n", obfn_w[g], e_dir ? 1'b1 : e_obfn);
      chk("R10 oe", oe_w[g], !e_dir);
      chk("R6 pins_o", pins_w[g], e_out);
      chk("R3 rdata", rdata_w[g], e_in);
      chk("R9 pc", pc_w[g], e_pc(g, e_dir, e_intr[g], e_ibf, e_obfn));
      chk("R9 mask", mask_w[g], g == 1 ? 8'h07 : (e_dir ? 8'h38 : 8'hC8));
    end
  endtask

  task automatic do_cfg(bit dir);
    cfg_in = dir; cfg_load = 1; tick(1); cfg_load = 0; tick(1);
    e_dir = dir; e_ibf = 0; e_obfn = 1;
    for (int g = 0; g < 2; g++) begin e_inte[g] = 0; e_intr[g] = 0; end
    check_all(); // R2
  endtask

  task automatic do_bsr(bit [2:0] b, bit v);
    bsr_bit = b; bsr_set = v; bsr_valid = 1; tick(1); bsr_valid = 0; tick(1);
    for (int g = 0; g < 2; g++) if (b == e_pos(g, e_dir)) e_inte[g] = v; // R8
  endtask

  task automatic do_hs(bit [7:0] d);
    pins_in = d; hs_n = 0; tick(4);
    if (e_dir) begin e_ibf = 1; e_in = d; end else e_obfn = 1;
    chk("R3/R6 during hs ibf", ibf_w[0], e_ibf);
    chk("R6 during hs obf", obfn_w[0], e_dir ? 1'b1 : e_obfn);
    hs_n = 1; tick(4);
    pins_in = ~d;
    for (int g = 0; g < 2; g++) if (e_inte[g]) e_intr[g] = 1; // R5/R7
    check_all();
  endtask

  task automatic do_read();
    rd_n = 0; tick(3);
    if (e_dir) for (int g = 0; g < 2; g++) e_intr[g] = 0;
    chk("R5 intr cleared mid-read", intr_w[0] | intr_w[1], e_intr[0] | e_intr[1]);
    chk("R4 ibf held mid-read", ibf_w[0], e_ibf);
    chk("R3 rdata mid-read", rdata_w[0], e_in);
    rd_n = 1; tick(2);
    if (e_dir) e_ibf = 0;
    check_all();
  endtask

  task automatic do_write(bit [7:0] d);
    wdata = d; wr_n = 0; tick(3);
    if (!e_dir) for (int g = 0; g < 2; g++) e_intr[g] = 0;
    chk("R7 intr cleared mid-write", intr_w[0] | intr_w[1], e_intr[0] | e_intr[1]);
    chk("R6 obf unchanged mid-write", obfn_w[0], e_dir ? 1'b1 : e_obfn);
    wr_n = 1; tick(2);
    if (!e_dir) begin e_out = d; e_obfn = 0; end // R10: ignored when input
    check_all();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3); rst_n = 1; tick(4);
    check_all(); // R1

    // directed: input, enable via wrong bit then right bit
    do_bsr(3'd6, 1);          // R8: not the input enable of either group
    do_hs(8'hA5);             // R3, no intr
    do_read();                // R4
    do_bsr(3'd4, 1);          // R8 upper only
    do_bsr(3'd2, 1);          // R8 lower
    do_hs(8'h3C);             // R5
    do_read();                // R5 clear on fall, R4 clear on rise
    do_write(8'hFF);          // R10 ignored in input

    // directed: output
    do_cfg(0);                // R2
    do_hs(8'h11);             // R10: ack-only effect, ibf stays 0
    do_bsr(3'd4, 1);          // R8: ignored for upper output
    do_bsr(3'd6, 1);
    do_write(8'h5A);          // R6
    do_hs(8'h00);             // R6, R7
    do_write(8'hC3);          // R7 clear on fall
    do_cfg(1);                // R2

    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0: do_cfg(1'($urandom % 2));
        1: do_bsr(3'($urandom % 8), 1'($urandom % 2));
        2: do_hs(8'($urandom));
        3: do_read();
        4: do_write(8'($urandom));
        default: do_bsr(e_pos($urandom % 2, e_dir), 1);
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule